// File: doc/BRIEF.md
# SPI Command Response Monitor

Once a command frame has gone out on the SPI link, this block collects and judges the target's reply. For each reply byte it asks an external byte shifter for one dummy transfer. Each requested transfer returns a received byte or reports a bus error. The reply is checked in two stages. In the first stage the block waits for the target to echo the opcode that was just sent. In the second stage it waits for a zero status byte. Each stage has its own bounded number of reads.

If the reply check fails and recovery is enabled, the block raises a reset request. A frame sender then emits the reset command (opcode 0xCF followed by three 0xFF bytes) and acknowledges. The block checks the response to that reset command in the same two-stage way. If that check also fails, the block makes a final attempt: it clocks a burst of all-ones bytes and inspects the last byte received. The transaction outcome is reported as a single one-cycle pulse on either `ok` or `fail`. A `linkLost` flag goes with `fail` when the final all-ones burst also fails.

Top module: `spi_rsp_monitor`

## Requirements
- R1: After `start`, the block issues one-byte transfers with `txByte` = 0x00 until a received byte equals the opcode that was captured at `start`.
- R2: After the echo is seen, the block continues with one-byte transfers (`txByte` = 0x00) until a received byte equals 0x00.
- R3: Each stage allows at most 1 + MAX_RETRY reads (11 by default). The read counter reloads whenever a stage starts. A stage that finishes its reads without a match fails the check.
- R4: `ok` pulses exactly one cycle after the `xferDone` cycle that delivered the accepted status byte. Every result pulse appears one cycle after the final `xferDone`.
- R5: `ok` and `fail` are never high together, and each is high for one cycle per transaction.
- R6: A `busErr` reported with `xferDone` ends the current check as a failure at once, without using up the remaining reads.
- R7: If `recoverEn` was high at `start` and the reply check fails, `rstReq` rises and stays high until `rstAck`. After that, the two-stage check runs again, now expecting echo opcode 0xCF.
- R8: If the reset response check fails, the block makes BURST_LEN (8) transfers with `txByte` = 0xFF and then pulses `fail`. `linkLost` is high in that same cycle if the last received byte is not 0xFF.
- R9: A failed transaction always ends in `fail`, including when recovery succeeds. With recovery disabled, `fail` follows the failing transfer directly and `rstReq` never rises.
- R10: A `start` pulse while a transaction is in progress is ignored, and only one transfer request is outstanding at any time.
- R11: After reset, `ok`, `fail`, `linkLost`, `rstReq` and `xferReq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin checking the reply to the command just sent |
| expOpcode | input | 8 | Opcode of that command, captured on `start` |
| recoverEn | input | 1 | Allow the reset and all-ones recovery, captured on `start` |
| xferReq | output | 1 | One-cycle request to the shifter for one byte transfer |
| txByte | output | 8 | Byte to transmit for the requested transfer |
| xferDone | input | 1 | Shifter finished a transfer |
| rxByte | input | 8 | Received byte, valid with `xferDone` |
| busErr | input | 1 | Shifter reports a bus error, valid with `xferDone` |
| rstReq | output | 1 | Request to send the reset command frame |
| rstAck | input | 1 | The reset command frame has been sent |
| ok | output | 1 | One-cycle pulse: transaction succeeded |
| fail | output | 1 | One-cycle pulse: transaction failed |
| linkLost | output | 1 | With `fail`: the all-ones recovery burst failed |

## Verification
Every outcome pulse (`ok`, `fail`, `linkLost`) is registered once, so it is due one cycle after the `xferDone` that completed the decision. The bench logs the cycle of each `xferDone` and of the result pulse at the falling edge, and requires a difference of exactly one. After the result, the bench keeps watching for a few more cycles to confirm the pulse lasted one cycle and had no follow-up. Transfer counts, reset requests and the number of 0xFF bytes sent are also tallied at the falling edge. Each is compared against values that the bench derives from the reply sequence it fed in.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;
  localparam logic [7:0] RST_OPCODE = 8'hCF;
  localparam logic [7:0] DUMMY_BYTE = 8'h00;
  localparam logic [7:0] ONES_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_ECHO, S_STAT, S_RST, S_BURST
  } rspState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capOp;        // capture opcode
    logic useRstOp;     // compare against the reset opcode
    logic cmpZero;      // compare against zero status
    logic cntLoad;      // reload per-stage read budget
    logic cntLoadBurst; // load burst length
    logic cntDec;       // consume one read
  } rspStrobe_t;
endpackage

// File: rtl/spi_rsp_dp.sv
module spi_rsp_dp
  import spi_rsp_pkg::*;
#(
  parameter int MAX_RETRY = 10,
  parameter int BURST_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  rspStrobe_t stb,
  input  logic [7:0] expOpcode,
  input  logic [7:0] rxByte,
  output logic       hit,
  output logic       cntZero,
  output logic       rxOnes
);
  localparam int CNT_MAX = (MAX_RETRY > BURST_LEN) ? MAX_RETRY : BURST_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [7:0]       opReg;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       target;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) opReg <= '0;
    else if (stb.capOp) opReg <= expOpcode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (stb.cntLoad)      cnt <= CNT_W'(MAX_RETRY);
    else if (stb.cntLoadBurst) cnt <= CNT_W'(BURST_LEN - 1);
    else if (stb.cntDec)       cnt <= cnt - 1'b1;
  end

  always_comb begin
    if (stb.cmpZero)       target = DUMMY_BYTE;
    else if (stb.useRstOp) target = RST_OPCODE;
    else                   target = opReg;
  end

  assign hit     = (rxByte == target);
  assign cntZero = (cnt == '0);
  assign rxOnes  = (rxByte == ONES_BYTE);

  // R3: the read budget never wraps below zero
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntDec |-> cnt != '0);
endmodule

// File: rtl/spi_rsp_ctl.sv
module spi_rsp_ctl
  import spi_rsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       recoverEn,
  input  logic       xferDone,
  input  logic       busErr,
  input  logic       rstAck,
  input  logic       hit,
  input  logic       cntZero,
  input  logic       rxOnes,
  output rspStrobe_t stb,
  output logic       xferReq,
  output logic [7:0] txByte,
  output logic       rstReq,
  output logic       ok,
  output logic       fail,
  output logic       linkLost
);
  rspState_t st, stNext;
  logic pend, pendNext, inRec, inRecNext, recEn, recEnNext;
  logic okNext, failNext, lostNext;

  always_comb begin
    stNext    = st;
    pendNext  = pend;
    inRecNext = inRec;
    recEnNext = recEn;
    okNext    = 1'b0;
    failNext  = 1'b0;
    lostNext  = 1'b0;
    stb       = '0;
    stb.useRstOp = inRec;
    stb.cmpZero  = (st == S_STAT);
    xferReq   = 1'b0;
    txByte    = DUMMY_BYTE;
    rstReq    = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        stb.capOp   = 1'b1;
        stb.cntLoad = 1'b1;
        recEnNext   = recoverEn;
        inRecNext   = 1'b0;
        pendNext    = 1'b0;
        stNext      = S_ECHO;
      end
      S_ECHO, S_STAT: begin
        if (!pend) begin
          xferReq  = 1'b1;
          pendNext = 1'b1;
        end else if (xferDone) begin
          pendNext = 1'b0;
          if (!busErr && hit) begin
            if (st == S_ECHO) begin
              stb.cntLoad = 1'b1;
              stNext      = S_STAT;
            end else begin
              okNext   = !inRec;
              failNext = inRec;
              stNext   = S_IDLE;
            end
          end else if (!busErr && !cntZero) begin
            stb.cntDec = 1'b1;
          end else if (inRec) begin
            stb.cntLoadBurst = 1'b1;
            stNext           = S_BURST;
          end else if (recEn) begin
            stNext = S_RST;
          end else begin
            failNext = 1'b1;
            stNext   = S_IDLE;
          end
        end
      end
      S_RST: begin
        rstReq = 1'b1;
        if (rstAck) begin
          inRecNext   = 1'b1;
          stb.cntLoad = 1'b1;
          pendNext    = 1'b0;
          stNext      = S_ECHO;
        end
      end
      S_BURST: begin
        txByte = ONES_BYTE;
        if (!pend) begin
          xferReq  = 1'b1;
          pendNext = 1'b1;
        end else if (xferDone) begin
          pendNext = 1'b0;
          if (busErr || cntZero) begin
            failNext = 1'b1;
            lostNext = busErr || !rxOnes;
            stNext   = S_IDLE;
          end else begin
            stb.cntDec = 1'b1;
          end
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; pend <= 1'b0; inRec <= 1'b0; recEn <= 1'b0;
      ok <= 1'b0; fail <= 1'b0; linkLost <= 1'b0;
    end else begin
      st <= stNext; pend <= pendNext; inRec <= inRecNext; recEn <= recEnNext;
      ok <= okNext; fail <= failNext; linkLost <= lostNext;
    end
  end

  p_okfail_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ok && fail));
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ok || fail) |=> !(ok || fail));
  p_ok_after_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    ok |-> $past(xferDone));
  p_single_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |=> !xferReq);
  p_rst_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && !rstAck) |=> rstReq);
  p_lost_with_fail_r8: assert property (@(posedge clk) disable iff (!rstN)
    linkLost |-> fail);
endmodule

// File: rtl/spi_rsp_monitor.sv
module spi_rsp_monitor
  import spi_rsp_pkg::*;
#(
  parameter int MAX_RETRY = 10,
  parameter int BURST_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] expOpcode,
  input  logic       recoverEn,
  output logic       xferReq,
  output logic [7:0] txByte,
  input  logic       xferDone,
  input  logic [7:0] rxByte,
  input  logic       busErr,
  output logic       rstReq,
  input  logic       rstAck,
  output logic       ok,
  output logic       fail,
  output logic       linkLost
);
  rspStrobe_t stb;
  logic hit, cntZero, rxOnes;

  spi_rsp_dp #(.MAX_RETRY(MAX_RETRY), .BURST_LEN(BURST_LEN)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .expOpcode(expOpcode), .rxByte(rxByte),
    .hit(hit), .cntZero(cntZero), .rxOnes(rxOnes)
  );

  spi_rsp_ctl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .recoverEn(recoverEn),
    .xferDone(xferDone), .busErr(busErr), .rstAck(rstAck),
    .hit(hit), .cntZero(cntZero), .rxOnes(rxOnes),
    .stb(stb), .xferReq(xferReq), .txByte(txByte), .rstReq(rstReq),
    .ok(ok), .fail(fail), .linkLost(linkLost)
  );
endmodule

// File: tb/sim_spi_rsp_monitor.sv
module sim_spi_rsp_monitor;
  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, recoverEn = 1'b0;
  logic [7:0] expOpcode = 8'h00;
  logic xferReq, xferDone = 1'b0, busErr = 1'b0, rstReq, rstAck = 1'b0;
  logic [7:0] txByte, rxByte = 8'h00;
  logic ok, fail, linkLost;

  always #2.5 clk = ~clk;

  spi_rsp_monitor u0 (.*);

  int nChecks = 0, nBad = 0;
  logic [7:0] seq [64];
  int idx = 0, errIdx = -1, waitCnt = 0, ackWait = 0;
  int cyc = 0, lastDone = 0, resCyc = 0;
  int nXfer = 0, nFF = 0, nRst = 0, nOk = 0, nFail = 0, nLost = 0;
  logic prevRst = 1'b0;

  // shifter and frame sender model
  always @(posedge clk) begin
    cyc = cyc + 1;
    xferDone <= 1'b0; busErr <= 1'b0; rstAck <= 1'b0;
    if (xferReq) waitCnt <= 2;
    else if (waitCnt == 1) begin
      xferDone <= 1'b1; rxByte <= seq[idx]; busErr <= (idx == errIdx);
      idx <= idx + 1; waitCnt <= 0;
    end else if (waitCnt > 1) waitCnt <= waitCnt - 1;
    if (rstReq && !rstAck) begin
      if (ackWait == 2) begin rstAck <= 1'b1; ackWait <= 0; end
      else ackWait <= ackWait + 1;
    end
  end

  // observation away from the active edge
  always @(negedge clk) begin
    if (xferDone) begin nXfer++; lastDone = cyc; end
    if (xferReq && txByte == 8'hFF) nFF++;
    if (rstReq && !prevRst) nRst++;
    prevRst = rstReq;
    if (ok) begin nOk++; resCyc = cyc; end
    if (fail) begin nFail++; resCyc = cyc; end
    if (linkLost) nLost++;
  end

  task automatic check(input bit c, input string tag, input int act, input int exp);
    nChecks++;
    if (!c) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] op, eD, sD, rec, reD, rsD, lastB, expOk, expLost, expX, expR;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'hC9, 8'd0,  8'd0,  8'd1, 8'd0,  8'd0,  8'hFF, 8'd1, 8'd0, 8'd2,  8'd0},
    '{8'hCA, 8'd3,  8'd2,  8'd0, 8'd0,  8'd0,  8'hFF, 8'd1, 8'd0, 8'd7,  8'd0},
    '{8'hC3, 8'd10, 8'd10, 8'd0, 8'd0,  8'd0,  8'hFF, 8'd1, 8'd0, 8'd22, 8'd0},
    '{8'hC4, 8'd11, 8'd0,  8'd0, 8'd0,  8'd0,  8'hFF, 8'd0, 8'd0, 8'd11, 8'd0},
    '{8'hC7, 8'd0,  8'd11, 8'd0, 8'd0,  8'd0,  8'hFF, 8'd0, 8'd0, 8'd12, 8'd0},
    '{8'hC8, 8'd11, 8'd0,  8'd1, 8'd1,  8'd0,  8'hFF, 8'd0, 8'd0, 8'd14, 8'd1},
    '{8'hC9, 8'd11, 8'd0,  8'd1, 8'd11, 8'd0,  8'hFF, 8'd0, 8'd0, 8'd30, 8'd1},
    '{8'hCA, 8'd11, 8'd0,  8'd1, 8'd11, 8'd0,  8'h7F, 8'd0, 8'd1, 8'd30, 8'd1},
    '{8'hC3, 8'd0,  8'd11, 8'd1, 8'd0,  8'd11, 8'hFF, 8'd0, 8'd0, 8'd32, 8'd1}
  };

  int pos;
  // appends up to 11 reads for one stage; returns 1 if the stage matches
  function automatic bit addStage(input int n, input logic [7:0] tgt, input logic [7:0] junk);
    for (int i = 0; i < n && i < 11; i++) begin seq[pos] = junk; pos++; end
    if (n <= 10) begin seq[pos] = tgt; pos++; end
    return n <= 10;
  endfunction

  task automatic clearObs();
    idx = 0; errIdx = -1; nXfer = 0; nFF = 0; nRst = 0;
    nOk = 0; nFail = 0; nLost = 0; lastDone = 0; resCyc = 0;
  endtask

  task automatic fire(input logic [7:0] op, input logic rec);
    @(negedge clk);
    expOpcode = op; recoverEn = rec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitResult(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 600 && !seen; t++) begin
      @(negedge clk);
      #0.1;
      seen = (nOk + nFail) != 0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!ok && !fail && !linkLost && !rstReq && !xferReq, "R11 outputs idle in reset",
          {ok, fail, linkLost, rstReq, xferReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!ok && !fail && !rstReq && !xferReq, "R11 idle after reset",
          {ok, fail, rstReq, xferReq}, 0);

    for (int v = 0; v < NV; v++) begin
      bit seen, mainOk, rstOk;
      int expFF;
      pos = 0;
      for (int i = 0; i < 64; i++) seq[i] = 8'h55;
      mainOk = addStage(int'(VEC[v].eD), VEC[v].op, 8'h55);
      if (mainOk) mainOk = addStage(int'(VEC[v].sD), 8'h00, 8'h22);
      expFF = 0;
      if (!mainOk && VEC[v].rec[0]) begin
        rstOk = addStage(int'(VEC[v].reD), 8'hCF, 8'h55);
        if (rstOk) rstOk = addStage(int'(VEC[v].rsD), 8'h00, 8'h22);
        if (!rstOk) begin
          for (int i = 0; i < 7; i++) begin seq[pos] = 8'hAA; pos++; end
          seq[pos] = VEC[v].lastB; pos++;
          expFF = 8;
        end
      end
      clearObs();
      fire(VEC[v].op, VEC[v].rec[0]);
      waitResult(seen);
      check(seen, $sformatf("R9 vector %0d produced a result", v), int'(seen), 1);
      // R1 R2 R3 outcome and read count
      check(nOk == int'(VEC[v].expOk) && nFail == 1 - int'(VEC[v].expOk),
            $sformatf("R1 R2 R3 R9 vector %0d ok count", v), nOk, int'(VEC[v].expOk));
      check(nXfer == int'(VEC[v].expX), $sformatf("R3 vector %0d transfers", v),
            nXfer, int'(VEC[v].expX));
      check(nRst == int'(VEC[v].expR), $sformatf("R7 vector %0d reset requests", v),
            nRst, int'(VEC[v].expR));
      check(nFF == expFF, $sformatf("R8 vector %0d ones bytes sent", v), nFF, expFF);
      check(nLost == int'(VEC[v].expLost), $sformatf("R8 vector %0d linkLost", v),
            nLost, int'(VEC[v].expLost));
      check(resCyc == lastDone + 1, $sformatf("R4 vector %0d result latency", v),
            resCyc - lastDone, 1);
      check(nOk + nFail == 1, $sformatf("R5 vector %0d single pulse", v), nOk + nFail, 1);
    end

    // R6: bus error on the second read ends the check at once
    begin
      bit seen;
      clearObs();
      seq[0] = 8'h55; seq[1] = 8'hC9; seq[2] = 8'h00;
      errIdx = 1;
      fire(8'hC9, 1'b0);
      waitResult(seen);
      check(nFail == 1 && nOk == 0, "R6 bus error gives fail", nFail, 1);
      check(nXfer == 2, "R6 no further reads after bus error", nXfer, 2);
    end

    // R10: start and opcode change during a transaction are ignored
    begin
      bit seen;
      clearObs();
      seq[0] = 8'h33; seq[1] = 8'hC9; seq[2] = 8'h00;
      fire(8'hC9, 1'b0);
      repeat (2) @(negedge clk);
      expOpcode = 8'h33; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitResult(seen);
      check(nOk == 1 && nFail == 0, "R10 restart ignored, original opcode kept", nOk, 1);
      check(nXfer == 3, "R10 transfer count unchanged by restart", nXfer, 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nBad);
    $finish;
  end
endmodule